// File: doc/BRIEF.md
# Unary Register Inheritance Tracker

This block sits in a stream of captured instruction events on their way to monitoring software that keeps metadata for every register and memory location. It keeps one entry per architectural register. The entry records the single memory location whose metadata that register currently stands for. The block uses these entries to rewrite or drop metadata-propagation events. A load into a register is absorbed and only recorded. A later store from that register goes out as one memory-to-memory event from the original location. A move between registers copies the record and sends nothing. Chains of register moves therefore collapse into direct memory-to-memory events, and the software sees far fewer updates.

Only unary inheritance is tracked, meaning one source per register. An operation that combines a register with a second operand first resolves that register. The block emits a memory-to-register event for the pending inheritance and then forwards the operation unchanged. Any write to a memory location first resolves every register that still inherits from that location, in ascending register order. When tracking is switched off, events pass through untouched and the table is emptied.

Each event has a 3-bit type, a 32-bit source field and a 32-bit destination field. A register operand is given by the low 3 bits of its field. Both the input and the output use valid/ready. A beat transfers on a rising edge where valid and ready are both high. An offered output holds its value until it is taken. The input accepts a new event only when no event is held, or when the held event completes in the same cycle. The output can therefore stall the input combinationally, and the block sustains one event per cycle when nothing needs resolving.

Top module: `inherit_tracker`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and no register inherits from any location.
- R2: A memory-to-register event (type 0, source = address, destination = register in its low 3 bits) produces no output. It records that the register inherits from that address.
- R3: A register-to-memory event (type 1) whose source register inherits from A is emitted as memory-to-memory (type 2) with source A and the original destination. If the source register does not inherit, the event is emitted unchanged.
- R4: A register-to-register event (type 3) whose source register inherits copies that inheritance to the destination register and emits nothing. Otherwise it is emitted unchanged, and the destination register then holds its own metadata.
- R5: A binary event (type 6, destination register combined with source address) whose destination register inherits from A first emits memory-to-register (type 0, source A, destination = register index). It then emits the original event, and the register holds its own metadata afterwards.
- R6: An immediate-to-register event (type 4) is emitted unchanged and clears that register's inheritance.
- R7: Before a memory write (type 1, 2 or immediate-to-memory type 5) to address X is forwarded, every register inheriting from X gets one memory-to-register event (type 0, source X), lowest register first. Each of those registers then holds its own metadata.
- R8: An event accepted while enable is low is emitted unchanged. While enable is low and no tracked event is in flight, all inheritance is discarded.
- R9: While out_valid is high and out_ready is low, the output fields stay stable, out_valid stays high and in_ready is low.
- R10: An event of type 7 is emitted unchanged, triggers no resolution and leaves all inheritance as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Tracking on; sampled when an event is accepted |
| in_valid | input | 1 | Input event offered |
| in_ready | output | 1 | Input event can be taken |
| in_type | input | 3 | Input event type |
| in_src | input | 32 | Input source address or register |
| in_dst | input | 32 | Input destination address or register |
| out_valid | output | 1 | Output event offered |
| out_ready | input | 1 | Consumer takes output event |
| out_type | output | 3 | Output event type |
| out_src | output | 32 | Output source address or register |
| out_dst | output | 32 | Output destination address or register |

## Verification
On every cycle, the assertions check the handshake hold rules and that an absorbed load never shows on the output. They also check that a disabled event leaves the block unchanged, that resolution clears only live entries one at a time, and that a binary event goes out only after its destination entry is gone. Only the bench's event sequences can show the resulting values. These are the correct rewritten source addresses, the ascending order of conflict resolution, the collapse of register-move chains, and that a register's earlier history is truly lost after an immediate write or after tracking is switched off.

// File: rtl/ittr_pkg.sv
package ittr_pkg;
  typedef enum logic [2:0] {
    EV_M2R = 3'd0,
    EV_R2M = 3'd1,
    EV_M2M = 3'd2,
    EV_R2R = 3'd3,
    EV_I2R = 3'd4,
    EV_I2M = 3'd5,
    EV_BIN = 3'd6,
    EV_OTH = 3'd7
  } ev_kind_e;

  function automatic logic writes_memory(input ev_kind_e k);
    return (k == EV_R2M) || (k == EV_M2M) || (k == EV_I2M);
  endfunction
endpackage

// File: rtl/ittr_pick.sv
module ittr_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gnt[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ittr_table.sv
module ittr_table #(
  parameter int NREGS = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic                      wr_vld,
  input  logic [AW-1:0]             wr_addr,
  input  logic [NREGS-1:0]          flush_clr,
  input  logic [AW-1:0]             match_addr,
  output logic [NREGS-1:0]          ent_vld,
  output logic [NREGS-1:0][AW-1:0]  ent_addr,
  output logic [NREGS-1:0]          match
);
  for (genvar i = 0; i < NREGS; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[i]  <= 1'b0;
        ent_addr[i] <= '0;
      end else if (clr_all) begin
        ent_vld[i] <= 1'b0;
      end else if (wr_en && (wr_idx == IW'(i))) begin
        ent_vld[i]  <= wr_vld;
        ent_addr[i] <= wr_addr;
      end else if (flush_clr[i]) begin
        ent_vld[i] <= 1'b0;
      end
    end

    assign match[i] = ent_vld[i] && (ent_addr[i] == match_addr);

    // R7: resolution only ever targets a live entry
    p_flush_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_clr[i] |-> ent_vld[i]);

    // R7: a resolved entry is gone on the next cycle
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_clr[i] && !(wr_en && wr_idx == IW'(i))) |=> !ent_vld[i]);
  end

  // R8: turning tracking off empties the table
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (ent_vld == '0));
endmodule

// File: rtl/ittr_xform.sv
module ittr_xform
  import ittr_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic                      en,
  input  ev_kind_e                  kind,
  input  logic [AW-1:0]             src,
  input  logic [AW-1:0]             dst,
  input  logic [NREGS-1:0]          ent_vld,
  input  logic [NREGS-1:0][AW-1:0]  ent_addr,
  input  logic [NREGS-1:0]          match,
  output logic [NREGS-1:0]          flush_need,
  output logic                      fin_emit,
  output ev_kind_e                  fin_kind,
  output logic [AW-1:0]             fin_src,
  output logic [AW-1:0]             fin_dst,
  output logic                      upd_en,
  output logic [IW-1:0]             upd_idx,
  output logic                      upd_vld,
  output logic [AW-1:0]             upd_addr
);
  logic [IW-1:0] s_idx, d_idx;
  assign s_idx = src[IW-1:0];
  assign d_idx = dst[IW-1:0];

  // Registers that must be resolved before the final event may leave
  always_comb begin
    flush_need = '0;
    if (en) begin
      if (writes_memory(kind)) flush_need = match;
      else if (kind == EV_BIN) flush_need = ent_vld & (NREGS'(1) << d_idx);
    end
  end

  // State transition and final event
  always_comb begin
    fin_emit = 1'b1;
    fin_kind = kind;
    fin_src  = src;
    fin_dst  = dst;
    upd_en   = 1'b0;
    upd_idx  = d_idx;
    upd_vld  = 1'b0;
    upd_addr = '0;
    if (en) begin
      unique case (kind)
        EV_M2R: begin
          fin_emit = 1'b0;
          upd_en   = 1'b1;
          upd_vld  = 1'b1;
          upd_addr = src;
        end
        EV_R2R: begin
          upd_en = 1'b1;
          if (ent_vld[s_idx]) begin
            fin_emit = 1'b0;
            upd_vld  = 1'b1;
            upd_addr = ent_addr[s_idx];
          end
        end
        EV_R2M: begin
          if (ent_vld[s_idx]) begin
            fin_kind = EV_M2M;
            fin_src  = ent_addr[s_idx];
          end
        end
        EV_I2R, EV_BIN: begin
          upd_en = 1'b1;
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/inherit_tracker.sv
module inherit_tracker
  import ittr_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_type,
  input  logic [AW-1:0] in_src,
  input  logic [AW-1:0] in_dst,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_type,
  output logic [AW-1:0] out_src,
  output logic [AW-1:0] out_dst
);
  // Held event
  logic          cur_busy, cur_en;
  ev_kind_e      cur_kind;
  logic [AW-1:0] cur_src, cur_dst;

  // Table
  logic [NREGS-1:0]         ent_vld, match, flush_clr;
  logic [NREGS-1:0][AW-1:0] ent_addr;
  logic                     clr_all, tbl_wr;

  // Transform
  logic [NREGS-1:0] flush_need, sel_oh;
  logic [IW-1:0]    sel_idx, upd_idx;
  logic             sel_any, fin_emit, upd_en, upd_vld;
  ev_kind_e         fin_kind;
  logic [AW-1:0]    fin_src, fin_dst, upd_addr;

  logic accept, done;

  ittr_table #(.NREGS(NREGS), .AW(AW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (clr_all),
    .wr_en      (tbl_wr),
    .wr_idx     (upd_idx),
    .wr_vld     (upd_vld),
    .wr_addr    (upd_addr),
    .flush_clr  (flush_clr),
    .match_addr (cur_dst),
    .ent_vld    (ent_vld),
    .ent_addr   (ent_addr),
    .match      (match)
  );

  ittr_xform #(.NREGS(NREGS), .AW(AW)) u_xform (
    .en         (cur_busy && cur_en),
    .kind       (cur_kind),
    .src        (cur_src),
    .dst        (cur_dst),
    .ent_vld    (ent_vld),
    .ent_addr   (ent_addr),
    .match      (match),
    .flush_need (flush_need),
    .fin_emit   (fin_emit),
    .fin_kind   (fin_kind),
    .fin_src    (fin_src),
    .fin_dst    (fin_dst),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .upd_vld    (upd_vld),
    .upd_addr   (upd_addr)
  );

  ittr_pick #(.N(NREGS)) u_pick (
    .req (flush_need),
    .gnt (sel_oh),
    .idx (sel_idx),
    .any (sel_any)
  );

  // Output: pending resolutions first, then the final event
  assign out_valid = cur_busy && (sel_any || fin_emit);
  assign out_type  = sel_any ? EV_M2R : fin_kind;
  assign out_src   = sel_any ? ent_addr[sel_idx] : fin_src;
  assign out_dst   = sel_any ? AW'(sel_idx) : fin_dst;

  assign flush_clr = (cur_busy && sel_any && out_ready) ? sel_oh : '0;
  assign done      = cur_busy && !sel_any && (!fin_emit || out_ready);
  assign in_ready  = !cur_busy || done;
  assign accept    = in_valid && in_ready;
  assign tbl_wr    = done && upd_en;
  assign clr_all   = !enable && !(cur_busy && cur_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_busy <= 1'b0;
      cur_en   <= 1'b0;
      cur_kind <= EV_M2R;
      cur_src  <= '0;
      cur_dst  <= '0;
    end else if (accept) begin
      cur_busy <= 1'b1;
      cur_en   <= enable;
      cur_kind <= ev_kind_e'(in_type);
      cur_src  <= in_src;
      cur_dst  <= in_dst;
    end else if (done) begin
      cur_busy <= 1'b0;
    end
  end

  // R9: an offered beat holds until taken
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_type) &&
                                   $stable(out_src) && $stable(out_dst)));

  // R9: no new input while the output is stalled
  p_no_take_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2: an absorbed load never reaches the output
  p_absorb_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_busy && cur_en && cur_kind == EV_M2R) |-> !out_valid);

  // R8: with tracking off the held event goes out untouched
  p_pass_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_busy && !cur_en) |-> (out_valid && out_type == cur_kind &&
                               out_src == cur_src && out_dst == cur_dst));

  // R7: at most one register resolved per cycle
  p_one_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush_clr));

  // R5: a binary event leaves only after its register is resolved
  p_bin_resolved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_busy && cur_en && out_valid && out_type == EV_BIN) |->
      !ent_vld[cur_dst[IW-1:0]]);
endmodule

// File: tb/inherit_tracker_test.sv
module inherit_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NIN  = 26;
  localparam int NEXP = 23;

  localparam logic [2:0] M2R = 3'd0, R2M = 3'd1, M2M = 3'd2, R2R = 3'd3,
                         I2R = 3'd4, I2M = 3'd5, BIN = 3'd6, OTH = 3'd7;

  function automatic logic [66:0] ev(input logic [2:0] t, input logic [31:0] s,
                                     input logic [31:0] d);
    return {t, s, d};
  endfunction

  localparam logic [66:0] IN_V [NIN] = '{
    ev(M2R, 32'h100, 32'd1),  // R2 absorbed
    ev(R2M, 32'd1, 32'h200),  // R3 rewritten
    ev(R2M, 32'd2, 32'h204),  // R3 own register
    ev(R2R, 32'd1, 32'd3),    // R4 silent copy
    ev(R2M, 32'd3, 32'h208),  // R4
    ev(R2R, 32'd2, 32'd4),    // R4 own source
    ev(M2R, 32'h300, 32'd5),
    ev(BIN, 32'h400, 32'd5),  // R5
    ev(R2M, 32'd5, 32'h500),  // R5 now own
    ev(M2R, 32'h600, 32'd6),
    ev(I2R, 32'd0, 32'd6),    // R6
    ev(R2M, 32'd6, 32'h504),  // R6 cleared
    ev(M2R, 32'h100, 32'd7),
    ev(I2M, 32'd0, 32'h100),  // R7 three conflicts
    ev(R2M, 32'd3, 32'h700),  // R7 r3 own
    ev(M2R, 32'h800, 32'd0),
    ev(M2R, 32'h800, 32'd2),
    ev(R2M, 32'd0, 32'h800),  // R7 self conflict
    ev(M2R, 32'h900, 32'd4),
    ev(M2M, 32'hA00, 32'h900),// R7
    ev(OTH, 32'h123, 32'h456),// R10
    ev(M2R, 32'hB00, 32'd1),
    ev(OTH, 32'd0, 32'hB00),  // R10 no flush
    ev(R2M, 32'd1, 32'hC00),  // R10 state kept
    ev(M2R, 32'hD00, 32'd9),  // R2 low bits select r1
    ev(R2M, 32'd1, 32'hE00)
  };

  localparam logic [66:0] EXP_V [NEXP] = '{
    ev(M2M, 32'h100, 32'h200),
    ev(R2M, 32'd2, 32'h204),
    ev(M2M, 32'h100, 32'h208),
    ev(R2R, 32'd2, 32'd4),
    ev(M2R, 32'h300, 32'd5),
    ev(BIN, 32'h400, 32'd5),
    ev(R2M, 32'd5, 32'h500),
    ev(I2R, 32'd0, 32'd6),
    ev(R2M, 32'd6, 32'h504),
    ev(M2R, 32'h100, 32'd1),
    ev(M2R, 32'h100, 32'd3),
    ev(M2R, 32'h100, 32'd7),
    ev(I2M, 32'd0, 32'h100),
    ev(R2M, 32'd3, 32'h700),
    ev(M2R, 32'h800, 32'd0),
    ev(M2R, 32'h800, 32'd2),
    ev(R2M, 32'd0, 32'h800),
    ev(M2R, 32'h900, 32'd4),
    ev(M2M, 32'hA00, 32'h900),
    ev(OTH, 32'h123, 32'h456),
    ev(OTH, 32'd0, 32'hB00),
    ev(M2M, 32'hB00, 32'hC00),
    ev(M2M, 32'hD00, 32'hE00)
  };

  localparam string ETAG [NEXP] = '{
    "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R6", "R6", "R7", "R7", "R7",
    "R7", "R7", "R7", "R7", "R7", "R7", "R7", "R10", "R10", "R10", "R2"
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [2:0]  in_type = '0, out_type;
  logic [31:0] in_src = '0, in_dst = '0, out_src, out_dst;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inherit_tracker uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_type(out_type), .out_src(out_src), .out_dst(out_dst)
  );

  function automatic logic [66:0] out_ev();
    return {out_type, out_src, out_dst};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [66:0] act,
                     input logic [66:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_stream(input bit stall);
    int ii = 0, eo = 0, cyc = 0;
    bit held_v = 0;
    logic [66:0] held = '0;
    while ((ii < NIN || eo < NEXP) && cyc < 2000) begin
      @(negedge clk);
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      in_valid  = (ii < NIN);
      {in_type, in_src, in_dst} = (ii < NIN) ? IN_V[ii] : '0;
      #1;
      if (held_v) chk(out_valid && out_ev() == held, "R9", out_ev(), held);
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R9", {66'd0, in_ready}, 67'd0);
        held_v = 1; held = out_ev();
      end else held_v = 0;
      if (out_valid && out_ready) begin
        if (eo < NEXP) chk(out_ev() == EXP_V[eo], ETAG[eo], out_ev(), EXP_V[eo]);
        else chk(1'b0, "R10", out_ev(), '0);
        eo++;
      end
      if (in_valid && in_ready) ii++;
      cyc++;
    end
    chk(eo == NEXP, "R7", 67'(eo), 67'(NEXP));
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!out_valid, "R2", out_ev(), '0);
    end
  endtask

  task automatic send(input logic [66:0] e, input bit want, input logic [66:0] x,
                      input string tag);
    int seen = 0;
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; {in_type, in_src, in_dst} = e;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); in_valid = 1'b0; #1;
      if (out_valid) begin
        seen++;
        if (seen == 1) chk(want && out_ev() == x, tag, out_ev(), x);
      end
    end
    chk(seen == (want ? 1 : 0), tag, 67'(seen), 67'(want));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk(!out_valid, "R1", {66'd0, out_valid}, 67'd0);
    chk(in_ready, "R1", {66'd0, in_ready}, 67'd1);
    send(ev(R2M, 32'd1, 32'h40), 1, ev(R2M, 32'd1, 32'h40), "R1");

    do_reset();
    run_stream(0);
    do_reset();
    run_stream(1);  // R9 stalls

    // R8: disabled events pass unchanged and leave no record
    do_reset();
    enable = 1'b0;
    send(ev(M2R, 32'h100, 32'd1), 1, ev(M2R, 32'h100, 32'd1), "R8");
    enable = 1'b1;
    send(ev(R2M, 32'd1, 32'h200), 1, ev(R2M, 32'd1, 32'h200), "R8");
    send(ev(M2R, 32'h300, 32'd2), 0, '0, "R2");
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    send(ev(R2M, 32'd2, 32'h210), 1, ev(R2M, 32'd2, 32'h210), "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule